// File: doc/BRIEF.md
# Nearest-Level Duty Modulator for a Two-Leg Multilevel Bridge

This block drives a single-phase bridge built from two legs, each able to take one of `LEVELS` output levels, with state 0 as the lowest leg voltage. At every period-start strobe it captures a signed reference voltage, the voltage step between adjacent levels and the period length in clock cycles. It then works out where the reference sits between the two nearest line levels. The line level is the leg-A state minus the leg-B state. During the next period it applies the lower level first and then the upper level, for on-times that make the period average equal to the reference.

The reference is divided by the step to give a fixed-point position with `FRAC_W` fractional bits. The integer part, rounded toward minus infinity, is the lower line level. The fractional part sets the share of the period given to the upper level. A line level can be produced by several leg-state pairs. The block always uses the pair with the lowest leg voltages, which leaves one of the two legs at state 0. A reference beyond the outermost level holds that level for the whole period. The division is serial, so the block has a fixed one-period latency. The result of the values captured at one strobe is applied from the following strobe.

Top module: `nl_duty_mod`

## Requirements
- R1: While reset is asserted, and after it until the first result is applied, `valid_o` is 0 and both leg codes are 0.
- R2: The position of the reference is a = floor(vref·2^FRAC_W / step), read as a fixed-point number with FRAC_W fractional bits. The lower line level is floor(a) and the upper line level is floor(a)+1, so negative references round toward minus infinity (for example, -0.3 gives levels -1 and 0).
- R3: With P the captured period length, the upper level's on-time is t2 = round(frac(a)·P), with halves rounded up, and t1 = P − t2. In cycles 0 to t1−1 after the applying strobe the lower level is driven. From cycle t1 until the next strobe the upper level is driven.
- R4: Line level k ≥ 0 is driven as leg A = k, leg B = 0. Line level k < 0 is driven as leg A = 0, leg B = −k.
- R5: If floor(a) ≥ LEVELS−1, the whole period drives line level LEVELS−1, that is leg A = LEVELS−1 and leg B = 0.
- R6: If floor(a) < −(LEVELS−1), the whole period drives line level −(LEVELS−1), that is leg A = 0 and leg B = LEVELS−1.
- R7: The reference, step and period length are read only in a cycle with `period_start_i` high. Changes at any other time do not affect the outputs.
- R8: A strobe applies the result of the values captured at the previous strobe, provided the two strobes are at least REF_W+FRAC_W+1 cycles apart. `valid_o` rises in the cycle after the first strobe that applies a result.
- R9: Each leg code is at most LEVELS−1, and at least one of the two legs is at 0.
- R10: Between strobes the line level changes at most once, and only upward by exactly one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_start_i | input | 1 | Period-start strobe. Captures the inputs and applies the previous result |
| vref_i | input | REF_W | Signed reference voltage |
| step_i | input | STEP_W | Voltage between adjacent levels, nonzero |
| period_len_i | input | CNT_W | Period length in clock cycles |
| leg_a_o | output | $clog2(LEVELS) | Leg-A state code |
| leg_b_o | output | $clog2(LEVELS) | Leg-B state code |
| valid_o | output | 1 | Set once a result has been applied |

## Verification
Each result is due one period after its inputs are captured. The divider needs REF_W+FRAC_W cycles, and the outputs change only at the strobe edge that applies a result and at the edge where the period counter reaches t1. The bench therefore sends each test reference with one strobe and follows it, exactly P cycles later, with a second strobe that applies it. It then compares both leg codes and `valid_o` in each of the P cycles, half a clock after each edge, against a lower-then-upper schedule it computes itself. In one test the inputs are scrambled every cycle between strobes, with the expected schedule left unchanged.

// File: rtl/nldm_pkg.sv
package nldm_pkg;

  // Which boundary, if any, clipped the reference in a period.
  typedef enum logic [1:0] {
    SAT_NONE = 2'd0,
    SAT_HIGH = 2'd1,
    SAT_LOW  = 2'd2
  } sat_kind_e;

endpackage

// File: rtl/nldm_divider.sv
// Serial restoring divider: |vref| * 2^FRAC_W / step, one quotient bit per cycle.
module nldm_divider #(
  parameter int REF_W  = 16,
  parameter int STEP_W = 12,
  parameter int FRAC_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic signed [REF_W-1:0]  ref_i,
  input  logic [STEP_W-1:0]        step_i,
  output logic                     done_o,
  output logic                     neg_o,
  output logic                     rem_nz_o,
  output logic [REF_W+FRAC_W-1:0]  quot_o
);
  localparam int NUM_W = REF_W + FRAC_W;
  localparam int IDX_W = $clog2(NUM_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_W - 1);

  logic [NUM_W-1:0]  num_q;
  logic [NUM_W-1:0]  quot_q;
  logic [STEP_W-1:0] rem_q;
  logic [STEP_W-1:0] div_q;
  logic [IDX_W-1:0]  idx_q;
  logic              busy_q;
  logic              done_q;
  logic              neg_q;
  logic [STEP_W:0]   stage_w;

  function automatic logic [REF_W-1:0] magnitude(input logic signed [REF_W-1:0] v);
    logic [REF_W-1:0] u;
    u = v;
    return v[REF_W-1] ? (~u + 1'b1) : u;
  endfunction

  // Returns {next remainder, quotient bit}.
  function automatic logic [STEP_W:0] div_stage(input logic [STEP_W-1:0] rem,
                                                input logic              nbit,
                                                input logic [STEP_W-1:0] d);
    logic [STEP_W:0] trial;
    logic [STEP_W:0] diff;
    trial = {rem, nbit};
    diff  = trial - {1'b0, d};
    if (trial >= {1'b0, d}) return {diff[STEP_W-1:0], 1'b1};
    return {trial[STEP_W-1:0], 1'b0};
  endfunction

  assign stage_w = div_stage(rem_q, num_q[NUM_W-1], div_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      num_q  <= '0;
      quot_q <= '0;
      rem_q  <= '0;
      div_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      neg_q  <= 1'b0;
    end else if (start_i) begin
      num_q  <= {magnitude(ref_i), {FRAC_W{1'b0}}};
      quot_q <= '0;
      rem_q  <= '0;
      div_q  <= step_i;
      idx_q  <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
      neg_q  <= ref_i[REF_W-1];
    end else if (busy_q) begin
      rem_q  <= stage_w[STEP_W:1];
      quot_q <= {quot_q[NUM_W-2:0], stage_w[0]};
      num_q  <= {num_q[NUM_W-2:0], 1'b0};
      idx_q  <= idx_q + 1'b1;
      if (idx_q == LAST_IDX) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign done_o   = done_q;
  assign neg_o    = neg_q;
  assign rem_nz_o = (rem_q != '0);
  assign quot_o   = quot_q;

endmodule

// File: rtl/nldm_level_calc.sv
// Floor, clipping, duty split and lowest-pair selection; purely combinational.
module nldm_level_calc import nldm_pkg::*; #(
  parameter int LEVELS = 3,
  parameter int REF_W  = 16,
  parameter int FRAC_W = 8,
  parameter int CNT_W  = 10,
  parameter int LEG_W  = 2
) (
  input  logic [REF_W+FRAC_W-1:0] quot_i,
  input  logic                    neg_i,
  input  logic                    rem_nz_i,
  input  logic [CNT_W-1:0]        period_i,
  output logic [LEG_W-1:0]        s1a_o,
  output logic [LEG_W-1:0]        s1b_o,
  output logic [LEG_W-1:0]        s2a_o,
  output logic [LEG_W-1:0]        s2b_o,
  output logic [CNT_W-1:0]        t1_o,
  output sat_kind_e               sat_o
);
  localparam int NUM_W = REF_W + FRAC_W;
  localparam int AW    = NUM_W + 1;
  localparam int KW    = AW - FRAC_W;
  localparam int PW    = FRAC_W + CNT_W + 1;
  localparam logic signed [KW-1:0] TOP_LVL = KW'(LEVELS - 1);

  logic signed [AW-1:0] a_fx;
  logic signed [KW-1:0] k_lo;
  logic signed [KW-1:0] lvl1;
  logic signed [KW-1:0] lvl2;
  logic [FRAC_W-1:0]    frac;

  // Signed floor of the fixed-point quotient from magnitude, sign and remainder.
  function automatic logic signed [AW-1:0] floor_fix(input logic [NUM_W-1:0] q,
                                                     input logic neg,
                                                     input logic rnz);
    logic signed [AW-1:0] qs;
    qs = $signed({1'b0, q});
    if (!neg) return qs;
    return -qs - $signed({{(AW-1){1'b0}}, rnz});
  endfunction

  // round(f / 2^FRAC_W * p), halves up.
  function automatic logic [CNT_W-1:0] upper_share(input logic [FRAC_W-1:0] f,
                                                   input logic [CNT_W-1:0]  p);
    logic [PW-1:0] prod;
    logic [PW-1:0] shifted;
    prod    = {{(CNT_W+1){1'b0}}, f} * {{(FRAC_W+1){1'b0}}, p};
    prod    = prod + PW'(1 << (FRAC_W - 1));
    shifted = prod >> FRAC_W;
    return CNT_W'(shifted);
  endfunction

  // Lowest-voltage leg pair for a line level: {leg A, leg B}.
  function automatic logic [2*LEG_W-1:0] leg_pair(input logic signed [KW-1:0] lvl);
    logic signed [KW-1:0] mag;
    mag = -lvl;
    if (lvl >= 0) return {LEG_W'(lvl), {LEG_W{1'b0}}};
    return {{LEG_W{1'b0}}, LEG_W'(mag)};
  endfunction

  always_comb begin
    a_fx = floor_fix(quot_i, neg_i, rem_nz_i);
    k_lo = a_fx[AW-1:FRAC_W];
    frac = a_fx[FRAC_W-1:0];
    if (k_lo >= TOP_LVL) begin
      sat_o = SAT_HIGH;
      lvl1  = TOP_LVL;
      lvl2  = TOP_LVL;
      t1_o  = period_i;
    end else if (k_lo < -TOP_LVL) begin
      sat_o = SAT_LOW;
      lvl1  = -TOP_LVL;
      lvl2  = -TOP_LVL;
      t1_o  = period_i;
    end else begin
      sat_o = SAT_NONE;
      lvl1  = k_lo;
      lvl2  = k_lo + KW'(1);
      t1_o  = period_i - upper_share(frac, period_i);
    end
    {s1a_o, s1b_o} = leg_pair(lvl1);
    {s2a_o, s2b_o} = leg_pair(lvl2);
  end

endmodule

// File: rtl/nldm_sequencer.sv
// Holds the applied pair of states and walks the period: lower state, then upper.
module nldm_sequencer #(
  parameter int LEG_W = 2,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_i,
  input  logic [LEG_W-1:0] s1a_i,
  input  logic [LEG_W-1:0] s1b_i,
  input  logic [LEG_W-1:0] s2a_i,
  input  logic [LEG_W-1:0] s2b_i,
  input  logic [CNT_W-1:0] t1_i,
  output logic [LEG_W-1:0] leg_a_o,
  output logic [LEG_W-1:0] leg_b_o,
  output logic             valid_o
);
  logic [2*LEG_W-1:0] first_q;
  logic [2*LEG_W-1:0] second_q;
  logic [CNT_W-1:0]   t1_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               valid_q;
  logic               in_second;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q  <= '0;
      second_q <= '0;
      t1_q     <= '0;
      cnt_q    <= '0;
      valid_q  <= 1'b0;
    end else if (commit_i) begin
      first_q  <= {s1a_i, s1b_i};
      second_q <= {s2a_i, s2b_i};
      t1_q     <= t1_i;
      cnt_q    <= '0;
      valid_q  <= 1'b1;
    end else if (cnt_q != '1) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign in_second          = (cnt_q >= t1_q);
  assign {leg_a_o, leg_b_o} = in_second ? second_q : first_q;
  assign valid_o            = valid_q;

endmodule

// File: rtl/nl_duty_mod.sv
module nl_duty_mod import nldm_pkg::*; #(
  parameter  int LEVELS = 3,
  parameter  int REF_W  = 16,
  parameter  int STEP_W = 12,
  parameter  int FRAC_W = 8,
  parameter  int CNT_W  = 10,
  localparam int LEG_W  = $clog2(LEVELS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    period_start_i,
  input  logic signed [REF_W-1:0] vref_i,
  input  logic [STEP_W-1:0]       step_i,
  input  logic [CNT_W-1:0]        period_len_i,
  output logic [LEG_W-1:0]        leg_a_o,
  output logic [LEG_W-1:0]        leg_b_o,
  output logic                    valid_o
);
  localparam int NUM_W = REF_W + FRAC_W;

  logic             div_done;
  logic             div_neg;
  logic             div_rnz;
  logic [NUM_W-1:0] div_quot;
  logic [CNT_W-1:0] p_hold_q;
  logic             commit_w;
  sat_kind_e        sat_w;
  logic [LEG_W-1:0] s1a_w, s1b_w, s2a_w, s2b_w;
  logic [CNT_W-1:0] t1_w;

  // Period length travels with the reference it was captured alongside.
  always_ff @(posedge clk) begin
    if (!rst_n)              p_hold_q <= '0;
    else if (period_start_i) p_hold_q <= period_len_i;
  end

  assign commit_w = period_start_i && div_done;

  nldm_divider #(
    .REF_W (REF_W),
    .STEP_W(STEP_W),
    .FRAC_W(FRAC_W)
  ) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (period_start_i),
    .ref_i   (vref_i),
    .step_i  (step_i),
    .done_o  (div_done),
    .neg_o   (div_neg),
    .rem_nz_o(div_rnz),
    .quot_o  (div_quot)
  );

  nldm_level_calc #(
    .LEVELS(LEVELS),
    .REF_W (REF_W),
    .FRAC_W(FRAC_W),
    .CNT_W (CNT_W),
    .LEG_W (LEG_W)
  ) u_calc (
    .quot_i  (div_quot),
    .neg_i   (div_neg),
    .rem_nz_i(div_rnz),
    .period_i(p_hold_q),
    .s1a_o   (s1a_w),
    .s1b_o   (s1b_w),
    .s2a_o   (s2a_w),
    .s2b_o   (s2b_w),
    .t1_o    (t1_w),
    .sat_o   (sat_w)
  );

  nldm_sequencer #(
    .LEG_W(LEG_W),
    .CNT_W(CNT_W)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit_i(commit_w),
    .s1a_i   (s1a_w),
    .s1b_i   (s1b_w),
    .s2a_i   (s2a_w),
    .s2b_i   (s2b_w),
    .t1_i    (t1_w),
    .leg_a_o (leg_a_o),
    .leg_b_o (leg_b_o),
    .valid_o (valid_o)
  );

endmodule

// File: rtl/nldm_checker.sv
module nldm_checker import nldm_pkg::*; #(
  parameter int LEVELS = 3,
  parameter int LEG_W  = 2,
  parameter int CNT_W  = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             commit_i,
  input sat_kind_e        sat_i,
  input logic [CNT_W-1:0] p_hold_i,
  input logic [LEG_W-1:0] leg_a_i,
  input logic [LEG_W-1:0] leg_b_i,
  input logic             valid_i
);
  localparam logic [LEG_W-1:0] TOP = LEG_W'(LEVELS - 1);

  logic signed [LEG_W+1:0] line;
  assign line = $signed({2'b00, leg_a_i}) - $signed({2'b00, leg_b_i});

  assert_idle_outputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> (leg_a_i == '0 && leg_b_i == '0));

  assert_top_clip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && sat_i == SAT_HIGH) |=> (leg_a_i == TOP && leg_b_i == '0));

  assert_bottom_clip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && sat_i == SAT_LOW) |=> (leg_a_i == '0 && leg_b_i == TOP));

  assert_hold_between_strobes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(p_hold_i));

  assert_valid_on_apply_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_i) |-> $past(commit_i));

  assert_leg_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (leg_a_i <= TOP && leg_b_i <= TOP));

  assert_one_leg_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (leg_a_i == '0 || leg_b_i == '0));

  assert_single_step_up_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(commit_i) && !$stable(line)) |-> (line == $past(line) + (LEG_W+2)'(1)));

endmodule

bind nl_duty_mod nldm_checker #(
  .LEVELS(LEVELS),
  .LEG_W (LEG_W),
  .CNT_W (CNT_W)
) u_nldm_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (period_start_i),
  .commit_i(commit_w),
  .sat_i   (sat_w),
  .p_hold_i(p_hold_q),
  .leg_a_i (leg_a_o),
  .leg_b_i (leg_b_o),
  .valid_i (valid_o)
);

// File: tb/tb_nl_duty_mod.sv
module tb_nl_duty_mod;
  localparam int CLK_PERIOD = 10;
  localparam int LEVELS     = 3;
  localparam int REF_W      = 16;
  localparam int STEP_W     = 12;
  localparam int FRAC_W     = 8;
  localparam int CNT_W      = 10;
  localparam int LEG_W      = $clog2(LEVELS);
  localparam int WATCHDOG   = 20000;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    start = 1'b0;
  logic signed [REF_W-1:0] vref = '0;
  logic [STEP_W-1:0]       step = 12'd1;
  logic [CNT_W-1:0]        plen = 10'd40;
  logic [LEG_W-1:0]        leg_a;
  logic [LEG_W-1:0]        leg_b;
  logic                    valid;

  int checks   = 0;
  int errors   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nl_duty_mod #(
    .LEVELS(LEVELS),
    .REF_W (REF_W),
    .STEP_W(STEP_W),
    .FRAC_W(FRAC_W),
    .CNT_W (CNT_W)
  ) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .period_start_i(start),
    .vref_i        (vref),
    .step_i        (step),
    .period_len_i  (plen),
    .leg_a_o       (leg_a),
    .leg_b_o       (leg_b),
    .valid_o       (valid)
  );

  task automatic compare(input string req, input int ea, input int eb, input int ev);
    checks++;
    if (leg_a !== LEG_W'(ea) || leg_b !== LEG_W'(eb) || valid !== 1'(ev)) begin
      errors++;
      $display("FAIL %s: got a=%0d b=%0d valid=%0d, expected a=%0d b=%0d valid=%0d",
               req, leg_a, leg_b, valid, ea, eb, ev);
    end
  endtask

  // One-cycle strobe driven at a falling edge; returns one falling edge later.
  task automatic pulse(input int r, input int s, input int p);
    vref  = REF_W'(r);
    step  = STEP_W'(s);
    plen  = CNT_W'(p);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Expected schedule from the requirements: floor, clip, split, lowest pair.
  task automatic model(input int r, input int s, input int p,
                       output int e1a, output int e1b, output int e2a, output int e2b,
                       output int et1);
    longint num, q, k, fr;
    int top, l1, l2;
    top = LEVELS - 1;
    num = longint'(r) * (longint'(1) << FRAC_W);
    q   = num / s;
    if (num < 0 && q * s != num) q = q - 1;
    k   = q / (longint'(1) << FRAC_W);
    if (q < 0 && k * (longint'(1) << FRAC_W) != q) k = k - 1;
    fr  = q - k * (longint'(1) << FRAC_W);
    if (k >= top) begin
      l1 = top; l2 = top; et1 = p;
    end else if (k < -top) begin
      l1 = -top; l2 = -top; et1 = p;
    end else begin
      l1  = int'(k);
      l2  = l1 + 1;
      et1 = p - int'((fr * p + (longint'(1) << (FRAC_W - 1))) >> FRAC_W);
    end
    e1a = (l1 >= 0) ? l1 : 0;
    e1b = (l1 >= 0) ? 0 : -l1;
    e2a = (l2 >= 0) ? l2 : 0;
    e2b = (l2 >= 0) ? 0 : -l2;
  endtask

  // Capture a reference, apply it with the next strobe P cycles later, then check
  // every cycle of that period. Each per-cycle comparison also covers R9 and R10.
  task automatic run_period(input string req, input int r, input int s, input int p,
                            input bit scramble);
    int e1a, e1b, e2a, e2b, et1;
    model(r, s, p, e1a, e1b, e2a, e2b, et1);
    pulse(r, s, p);
    repeat (p - 1) @(negedge clk);
    pulse(0, s, p);
    for (int j = 0; j < p; j++) begin
      if (scramble) begin
        vref = REF_W'(j * 911 - 20000);
        step = STEP_W'(j + 3);
        plen = CNT_W'(j + 30);
      end
      if (j < et1) compare(req, e1a, e1b, 1);
      else         compare(req, e2a, e2b, 1);
      if (j < p - 1) @(negedge clk);
    end
  endtask

  task automatic t_reset_and_first_result;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1 during reset", 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset", 0, 0, 0);
    pulse(150, 100, 40);
    repeat (38) @(negedge clk);
    compare("R8 nothing applied before second strobe", 0, 0, 0);
  endtask

  task automatic t_fractions;
    run_period("R3 R4 positive half step", 150, 100, 40, 1'b0);
    run_period("R2 negative half step", -150, 100, 40, 1'b0);
    run_period("R2 small negative floors to -1", -30, 100, 40, 1'b0);
    run_period("R3 rounding to full upper share", 99, 100, 40, 1'b0);
    run_period("R3 other period length", 37, 50, 64, 1'b0);
    run_period("R3 long period", 175, 100, 300, 1'b0);
  endtask

  task automatic t_exact_levels;
    run_period("R4 exact level +1", 100, 100, 40, 1'b0);
    run_period("R4 zero reference", 0, 100, 40, 1'b0);
    run_period("R4 exact level -2", -200, 100, 40, 1'b0);
  endtask

  task automatic t_clipping;
    run_period("R5 exact top level", 200, 100, 40, 1'b0);
    run_period("R5 just above top", 250, 100, 40, 1'b0);
    run_period("R5 far above top", 500, 100, 40, 1'b0);
    run_period("R6 just below bottom", -250, 100, 40, 1'b0);
    run_period("R6 far below bottom", -500, 100, 40, 1'b0);
  endtask

  task automatic t_ignored_inputs;
    run_period("R7 inputs changed between strobes", 60, 100, 48, 1'b1);
  endtask

  initial begin
    t_reset_and_first_result();
    t_fractions();
    t_exact_levels();
    t_clipping();
    t_ignored_inputs();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule